// File: doc/BRIEF.md
# Byte-Accessed 16-Bit Timer with Two Compare Channels

This block is a 16-bit up-counter seen by an 8-bit processor through a small register window. Two compare channels watch the count and each drives a match flag and a waveform pin. A capture register snapshots the count on an external strobe. The count advances once per cycle in which the `tick` enable is high, so a prescaler elsewhere sets the rate.

The bus is 8 bits wide but every wide register is 16 bits. A single holding byte is shared by all wide registers, and it makes each two-byte transfer atomic. Software writes the upper byte first, which lands only in the holding byte. The lower-byte write then moves both halves into the target in one cycle. On a read, software takes the lower byte first. That read parks the upper half in the holding byte, and a later upper-byte read returns the parked value.

Two counting modes exist. In free-running mode the count wraps at the top of its range and raises an overflow flag. In clear-on-compare mode compare A is the period.

Top module: `tmr16_byte`

## Requirements
- R1: After reset the counter, both compare registers, the capture register, the holding byte, the control byte, all flags and both waveform pins are zero.
- R2: The wide-register locations are counter 0/1, compare A 2/3, compare B 4/5 and capture 6/7, with the even address low and the odd address high. Writing an odd location changes only the holding byte. Writing an even location loads {holding byte, written byte} into that register in one cycle.
- R3: Reading an even location returns the low half of that register and copies its high half into the holding byte. Reading any odd location returns the holding byte, so a two-read sequence yields one consistent 16-bit snapshot even while the count is moving.
- R4: The holding byte is shared by all wide registers. An upper byte written at one register's odd location is used by a lower-byte write to any other register.
- R5: In free-running mode (control bit 0 = 0) the counter rises by one on each `tick`. It is unchanged when `tick` is low. On a tick at 0xFFFF it goes to 0 and sets the overflow flag.
- R6: In clear-on-compare mode (control bit 0 = 1), a tick while the count equals compare A reloads 0, and the overflow flag is never set by counting. This reload happens on equality even when the compare match is suppressed under R8.
- R7: On a tick where the count equals a channel's compare value, that channel's flag is set and its waveform action is applied. Control bits [2:1] give channel A's mode and bits [4:3] give channel B's: 00 disconnected (pin held 0, state frozen), 01 toggle, 10 drive 0, 11 drive 1. The control byte is at address 8.
- R8: A CPU write to the counter suppresses compare matches on both channels for the next tick. No flag is set and no waveform action is taken on that tick.
- R9: Writing 1 to bit 0 (channel A) or bit 1 (channel B) of address 9 applies that channel's waveform action at once. It sets no flag and never reloads the counter.
- R10: Address 9 always reads zero.
- R11: Flags are at address 10: bit 0 channel A, bit 1 channel B, bit 2 overflow. Writing 1 to a bit clears it. A set event in the same cycle wins over the clear.
- R12: A one-cycle pulse on `cap_in` copies the current count into the capture register. A same-cycle CPU write to the capture register takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable, one timer step per high cycle |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe (side effect on even wide locations) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the cycle of `rd_en` |
| cap_in | input | 1 | Capture strobe |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| flag_a | output | 1 | Channel A match flag |
| flag_b | output | 1 | Channel B match flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
Directed sequences drive the counter through each mode's boundary. One is the 0xFFFF wrap, which must raise overflow. Another is the compare-A period reload, which must not. A third is a counter write landing on the compare value, which separates a suppressed match from a real one. A split read across a tick-driven carry shows whether the upper byte comes from the holding byte or from the live count. A random phase follows and mixes bus traffic, force strobes, flag clears and ticks. Compare and count values are kept small so that matches, clears, forces and set-versus-clear collisions happen often, and every cycle is compared with a bench model.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [1:0] {
      WM_OFF = 2'b00,
      WM_TOG = 2'b01,
      WM_LOW = 2'b10,
      WM_HIGH = 2'b11
   } wmode_t;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd8;
   localparam logic [ADDR_W-1:0] A_FORCE = 4'd9;
   localparam logic [ADDR_W-1:0] A_FLAGS = 4'd10;

   function automatic logic wave_apply(input wmode_t m, input logic cur);
      case (m)
         WM_TOG:  return ~cur;
         WM_LOW:  return 1'b0;
         WM_HIGH: return 1'b1;
         default: return cur;
      endcase
   endfunction
endpackage

// File: rtl/tmr16_bus.sv
module tmr16_bus
   import tmr16_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16,
   parameter int NCH   = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [BUS_W-1:0]             wdata,
   input  logic [CNT_W-1:0]             cnt_q,
   input  logic [NCH-1:0][CNT_W-1:0]    cmp_q,
   input  logic [CNT_W-1:0]             cap_q,
   input  logic [NCH:0]                 flags_q,
   output logic [BUS_W-1:0]             rdata,
   output logic [CNT_W-1:0]             wval,
   output logic                         cnt_wr,
   output logic [NCH-1:0]               cmp_wr,
   output logic                         cap_wr,
   output logic [NCH-1:0]               frc,
   output logic [NCH:0]                 flag_clr,
   output logic                         ctc,
   output logic [NCH-1:0][1:0]          wmode
);
   localparam int CTRL_W = 1 + 2*NCH;

   if (NCH != 2) begin : g_bad_nch
      $error("tmr16_bus: address map holds exactly two compare channels");
   end

   logic [BUS_W-1:0]  hold_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  sel16;
   logic              wide, lo, hi;

   assign wide = (addr[3] == 1'b0);
   assign lo   = wide && !addr[0];
   assign hi   = wide && addr[0];

   always_comb begin
      case (addr[2:1])
         2'd0:    sel16 = cnt_q;
         2'd1:    sel16 = cmp_q[0];
         2'd2:    sel16 = cmp_q[1];
         default: sel16 = cap_q;
      endcase
   end

   assign wval   = {hold_q, wdata};
   assign cnt_wr = wr_en && lo && (addr[2:1] == 2'd0);
   assign cap_wr = wr_en && lo && (addr[2:1] == 2'd3);

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign cmp_wr[i] = wr_en && lo && (addr[2:1] == 2'(i + 1));
      assign wmode[i]  = ctrl_q[2*i+1 +: 2];
   end

   assign frc      = (wr_en && addr == A_FORCE) ? wdata[NCH-1:0] : '0;
   assign flag_clr = (wr_en && addr == A_FLAGS) ? wdata[NCH:0]   : '0;
   assign ctc      = ctrl_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
         ctrl_q <= '0;
      end else begin
         if (wr_en && hi)
            hold_q <= wdata;
         else if (rd_en && lo)
            hold_q <= sel16[CNT_W-1:BUS_W];
         if (wr_en && addr == A_CTRL)
            ctrl_q <= wdata[CTRL_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (lo)
         rdata = sel16[BUS_W-1:0];
      else if (hi)
         rdata = hold_q;
      else if (addr == A_CTRL)
         rdata = BUS_W'(ctrl_q);
      else if (addr == A_FLAGS)
         rdata = BUS_W'(flags_q);
   end

   // R10: force location never returns data
   p_force_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == A_FORCE) |-> (rdata == '0));
   // R3: an odd read right after an even read of the same register returns the parked upper half
   p_split_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && lo && !wr_en) |=> (hi && $past(addr[2:1]) == addr[2:1]) |-> (rdata == $past(sel16[CNT_W-1:BUS_W])));
endmodule

// File: rtl/tmr16_cnt.sv
module tmr16_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ctc,
   input  logic [CNT_W-1:0] top,
   input  logic             cnt_wr,
   input  logic             cap_wr,
   input  logic [CNT_W-1:0] wval,
   input  logic             cap_in,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cap_q,
   output logic             ovf_q,
   output logic             blk_q
);
   logic at_top, at_max, ovf_set;

   assign at_top  = (cnt_q == top);
   assign at_max  = &cnt_q;
   assign ovf_set = tick && !cnt_wr && !ctc && at_max;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         blk_q <= 1'b0;
         ovf_q <= 1'b0;
         cap_q <= '0;
      end else begin
         if (cnt_wr) begin
            cnt_q <= wval;
            blk_q <= 1'b1;
         end else if (tick) begin
            blk_q <= 1'b0;
            cnt_q <= (ctc && at_top) ? '0 : cnt_q + 1'b1;
         end
         if (ovf_set)
            ovf_q <= 1'b1;
         else if (ovf_clr)
            ovf_q <= 1'b0;
         if (cap_wr)
            cap_q <= wval;
         else if (cap_in)
            cap_q <= cnt_q;
      end
   end

   p_count_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && !(ctc && at_top)) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
   p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !cnt_wr) |=> $stable(cnt_q));
   p_wrap_ovf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && !ctc && at_max) |=> (ovf_q && cnt_q == '0));
   p_ctc_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !cnt_wr && ctc && at_top) |=> (cnt_q == '0));
   p_ctc_no_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctc && !ovf_q) |=> !ovf_q);
   p_capture_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_in && !cap_wr) |=> (cap_q == $past(cnt_q)));
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
   import tmr16_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             blk,
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             cmp_wr,
   input  logic [CNT_W-1:0] wval,
   input  wmode_t           mode,
   input  logic             frc,
   input  logic             clr,
   output logic [CNT_W-1:0] cmp_q,
   output logic             flag_q,
   output logic             wave_o
);
   logic hit, wave_q;

   assign hit    = tick && !blk && (cnt_q == cmp_q);
   assign wave_o = (mode != WM_OFF) && wave_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmp_q  <= '0;
         flag_q <= 1'b0;
         wave_q <= 1'b0;
      end else begin
         if (cmp_wr)
            cmp_q <= wval;
         if (hit)
            flag_q <= 1'b1;
         else if (clr)
            flag_q <= 1'b0;
         if (hit || frc)
            wave_q <= wave_apply(mode, wave_q);
      end
   end

   p_force_no_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (frc && !flag_q && !(tick && !blk && cnt_q == cmp_q)) |=> !flag_q);
   p_blocked_no_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && blk && !flag_q) |=> !flag_q);
   p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !(tick && !blk && cnt_q == cmp_q)) |=> !flag_q);
   p_match_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !blk && cnt_q == cmp_q) |=> flag_q);
endmodule

// File: rtl/tmr16_byte.sv
module tmr16_byte
   import tmr16_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic              cap_in,
   output logic              wave_a,
   output logic              wave_b,
   output logic              flag_a,
   output logic              flag_b,
   output logic              flag_ovf
);
   localparam int NCH = 2;

   if (CNT_W != 2*BUS_W) begin : g_bad_width
      $error("tmr16_byte: counter must be exactly two bus bytes wide");
   end

   logic [CNT_W-1:0]           cnt_q, cap_q, wval;
   logic [NCH-1:0][CNT_W-1:0]  cmp_v;
   logic [NCH-1:0][1:0]        wmode;
   logic [NCH-1:0]             cmp_wr, frc, flag_v, wave_v;
   logic [NCH:0]               flag_clr;
   logic                       cnt_wr, cap_wr, ctc, ovf_q, blk_q;

   tmr16_bus #(.BUS_W(BUS_W), .CNT_W(CNT_W), .NCH(NCH)) u_bus (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .cnt_q(cnt_q), .cmp_q(cmp_v), .cap_q(cap_q),
      .flags_q({ovf_q, flag_v}), .rdata(rdata), .wval(wval), .cnt_wr(cnt_wr),
      .cmp_wr(cmp_wr), .cap_wr(cap_wr), .frc(frc), .flag_clr(flag_clr),
      .ctc(ctc), .wmode(wmode)
   );

   tmr16_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ctc(ctc), .top(cmp_v[0]),
      .cnt_wr(cnt_wr), .cap_wr(cap_wr), .wval(wval), .cap_in(cap_in),
      .ovf_clr(flag_clr[NCH]), .cnt_q(cnt_q), .cap_q(cap_q), .ovf_q(ovf_q),
      .blk_q(blk_q)
   );

   for (genvar i = 0; i < NCH; i++) begin : g_chan
      tmr16_chan #(.CNT_W(CNT_W)) u_chan (
         .clk(clk), .rst_n(rst_n), .tick(tick), .blk(blk_q), .cnt_q(cnt_q),
         .cmp_wr(cmp_wr[i]), .wval(wval), .mode(wmode_t'(wmode[i])),
         .frc(frc[i]), .clr(flag_clr[i]), .cmp_q(cmp_v[i]),
         .flag_q(flag_v[i]), .wave_o(wave_v[i])
      );
   end

   assign wave_a   = wave_v[0];
   assign wave_b   = wave_v[1];
   assign flag_a   = flag_v[0];
   assign flag_b   = flag_v[1];
   assign flag_ovf = ovf_q;

   // R1: everything observable is clear in the first cycle after reset
   p_reset_clear_r1: assert property (@(posedge clk)
      !rst_n |=> (!flag_a && !flag_b && !flag_ovf && !wave_a && !wave_b));
   // R9: a force strobe alone never moves the counter
   p_force_keeps_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((|frc) && !tick && !cnt_wr) |=> $stable(cnt_q));
endmodule

// File: tb/sim_tmr16_byte.sv
module sim_tmr16_byte;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0, cap_in = 1'b0;
   logic [3:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       wave_a, wave_b, flag_a, flag_b, flag_ovf;

   int n_chk = 0, n_err = 0;
   logic [7:0] last_rd;

   // bench model
   logic [15:0] m_cnt, m_cap;
   logic [15:0] m_cmp [2];
   logic [7:0]  m_hold;
   logic [4:0]  m_ctrl;
   logic        m_fa, m_fb, m_ovf, m_blk, m_wa, m_wb;

   tmr16_byte u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .cap_in(cap_in),
      .wave_a(wave_a), .wave_b(wave_b), .flag_a(flag_a), .flag_b(flag_b),
      .flag_ovf(flag_ovf)
   );

   always #10 clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] m_r16(input logic [1:0] idx);
      case (idx)
         2'd0: return m_cnt;
         2'd1: return m_cmp[0];
         2'd2: return m_cmp[1];
         default: return m_cap;
      endcase
   endfunction

   function automatic logic [7:0] m_rd(input logic [3:0] a);
      logic [15:0] v;
      v = m_r16(a[2:1]);
      if (a < 4'd8) return a[0] ? m_hold : v[7:0];
      if (a == 4'd8) return {3'b000, m_ctrl};
      if (a == 4'd10) return {5'b00000, m_ovf, m_fb, m_fa};
      return 8'h00;
   endfunction

   function automatic logic wv(input logic [1:0] md, input logic cur);
      case (md)
         2'b01: return ~cur;
         2'b10: return 1'b0;
         2'b11: return 1'b1;
         default: return cur;
      endcase
   endfunction

   task automatic step(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic t, input logic c);
      logic [15:0] val, n_cnt, n_cap, n_c0, n_c1;
      logic [7:0]  n_hold;
      logic [4:0]  n_ctrl;
      logic        n_fa, n_fb, n_ovf, n_blk, n_wa, n_wb, ha, hb;
      logic [1:0]  fr;
      wr_en = w; rd_en = r; addr = a; wdata = d; tick = t; cap_in = c;
      #1;
      if (r) begin
         last_rd = rdata;
         chk($sformatf("R3 read addr %0d", a), rdata, m_rd(a));
      end
      val = {m_hold, d};
      n_cnt = m_cnt; n_cap = m_cap; n_c0 = m_cmp[0]; n_c1 = m_cmp[1];
      n_hold = m_hold; n_ctrl = m_ctrl; n_fa = m_fa; n_fb = m_fb;
      n_ovf = m_ovf; n_blk = m_blk; n_wa = m_wa; n_wb = m_wb;
      ha = t && !m_blk && (m_cnt == m_cmp[0]);
      hb = t && !m_blk && (m_cnt == m_cmp[1]);
      fr = (w && a == 4'd9) ? d[1:0] : 2'b00;
      if (w && a < 4'd8 && a[0]) n_hold = d;
      else if (r && a < 4'd8 && !a[0]) n_hold = m_r16(a[2:1]) >> 8;
      if (w && a == 4'd0) begin
         n_cnt = val; n_blk = 1'b1;
      end else if (t) begin
         n_blk = 1'b0;
         n_cnt = (m_ctrl[0] && m_cnt == m_cmp[0]) ? 16'h0 : m_cnt + 16'h1;
      end
      if (w && a == 4'd10) begin
         if (d[0]) n_fa = 1'b0;
         if (d[1]) n_fb = 1'b0;
         if (d[2]) n_ovf = 1'b0;
      end
      if (t && !(w && a == 4'd0) && !m_ctrl[0] && m_cnt == 16'hFFFF) n_ovf = 1'b1;
      if (ha) n_fa = 1'b1;
      if (hb) n_fb = 1'b1;
      if ((ha || fr[0]) && m_ctrl[2:1] != 2'b00) n_wa = wv(m_ctrl[2:1], m_wa);
      if ((hb || fr[1]) && m_ctrl[4:3] != 2'b00) n_wb = wv(m_ctrl[4:3], m_wb);
      if (w && a == 4'd6) n_cap = val;
      else if (c) n_cap = m_cnt;
      if (w && a == 4'd2) n_c0 = val;
      if (w && a == 4'd4) n_c1 = val;
      if (w && a == 4'd8) n_ctrl = d[4:0];
      @(posedge clk);
      m_cnt = n_cnt; m_cap = n_cap; m_cmp[0] = n_c0; m_cmp[1] = n_c1;
      m_hold = n_hold; m_ctrl = n_ctrl; m_fa = n_fa; m_fb = n_fb;
      m_ovf = n_ovf; m_blk = n_blk; m_wa = n_wa; m_wb = n_wb;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; tick = 1'b0; cap_in = 1'b0;
      chk("R7 wave A", wave_a, (m_ctrl[2:1] != 2'b00) && m_wa);
      chk("R7 wave B", wave_b, (m_ctrl[4:3] != 2'b00) && m_wb);
      chk("R11 flag A", flag_a, m_fa);
      chk("R11 flag B", flag_b, m_fb);
      chk("R5 overflow flag", flag_ovf, m_ovf);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      step(1'b1, 1'b0, a, d, 1'b0, 1'b0);
   endtask

   task automatic wr16(input logic [3:0] lo_a, input logic [15:0] v);
      wr(lo_a | 4'd1, v[15:8]);
      wr(lo_a, v[7:0]);
   endtask

   task automatic rd16(input logic [3:0] lo_a, input logic t, output logic [15:0] v);
      step(1'b0, 1'b1, lo_a, 8'h00, t, 1'b0);
      v[7:0] = last_rd;
      step(1'b0, 1'b1, lo_a | 4'd1, 8'h00, t, 1'b0);
      v[15:8] = last_rd;
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 1'b0);
   endtask

   bit done = 1'b0;
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      int seed;
      seed = $urandom(32'd24681);
      m_cnt = '0; m_cap = '0; m_cmp[0] = '0; m_cmp[1] = '0; m_hold = '0;
      m_ctrl = '0; m_fa = 0; m_fb = 0; m_ovf = 0; m_blk = 0; m_wa = 0; m_wb = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 flags", {flag_a, flag_b, flag_ovf}, 3'b000);
      chk("R1 waves", {wave_a, wave_b}, 2'b00);
      rd16(4'd0, 1'b0, v); chk("R1 counter", v, 16'h0000);
      rd16(4'd2, 1'b0, v); chk("R1 compare A", v, 16'h0000);
      rd16(4'd6, 1'b0, v); chk("R1 capture", v, 16'h0000);
      // R2 high byte alone does not commit
      wr(4'd3, 8'h12);
      step(1'b0, 1'b1, 4'd2, 8'h00, 1'b0, 1'b0);
      chk("R2 uncommitted low", last_rd, 8'h00);
      wr16(4'd2, 16'h1234);
      rd16(4'd2, 1'b0, v); chk("R2 committed compare A", v, 16'h1234);
      // R4 shared holding byte
      wr(4'd1, 8'hAB);
      wr(4'd4, 8'hCD);
      rd16(4'd4, 1'b0, v); chk("R4 shared hold into compare B", v, 16'hABCD);
      rd16(4'd0, 1'b0, v); chk("R4 counter untouched", v, 16'h0000);
      // R3 split read across a carry
      wr16(4'd0, 16'h00FF);
      ticks(1);
      wr16(4'd0, 16'h00FF);
      rd16(4'd0, 1'b1, v); chk("R3 atomic snapshot", v, 16'h00FF);
      // R5 wrap and overflow
      wr16(4'd0, 16'hFFFE);
      ticks(1);
      chk("R5 no overflow before wrap", flag_ovf, 1'b0);
      ticks(1);
      chk("R5 overflow at wrap", flag_ovf, 1'b1);
      rd16(4'd0, 1'b0, v); chk("R5 wrapped to zero", v, 16'h0000);
      wr(4'd10, 8'h04);
      chk("R11 overflow cleared", flag_ovf, 1'b0);
      // R6/R7 clear-on-compare with toggle on A
      wr16(4'd2, 16'h0005);
      wr16(4'd4, 16'h0100);
      wr(4'd8, 8'b000_00_01_1);
      wr16(4'd0, 16'h0003);
      ticks(3);
      chk("R7 flag A on match", flag_a, 1'b1);
      chk("R7 toggle A", wave_a, 1'b1);
      rd16(4'd0, 1'b0, v); chk("R6 reload to zero", v, 16'h0000);
      chk("R6 no overflow", flag_ovf, 1'b0);
      // R8 suppression after a counter write
      wr(4'd10, 8'h01);
      chk("R11 flag A cleared", flag_a, 1'b0);
      wr16(4'd0, 16'h0005);
      ticks(1);
      chk("R8 no flag on suppressed tick", flag_a, 1'b0);
      chk("R8 no wave action", wave_a, 1'b1);
      // R9 force: action, no flag, no reload
      wr(4'd8, 8'b000_11_01_1);
      wr16(4'd0, 16'h0005);
      wr(4'd9, 8'h03);
      chk("R9 force toggles A", wave_a, 1'b0);
      chk("R9 force sets B", wave_b, 1'b1);
      chk("R9 no flags", {flag_a, flag_b}, 2'b00);
      rd16(4'd0, 1'b0, v); chk("R9 counter kept", v, 16'h0005);
      // R10
      step(1'b0, 1'b1, 4'd9, 8'h00, 1'b0, 1'b0);
      chk("R10 force reads zero", last_rd, 8'h00);
      // R12 capture
      wr(4'd8, 8'h00);
      wr16(4'd0, 16'h1234);
      step(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 1'b1);
      rd16(4'd6, 1'b0, v); chk("R12 capture value", v, 16'h1234);
      // random phase
      for (int n = 0; n < 6000; n++) begin
         int op;
         logic [3:0] a;
         logic [7:0] d;
         op = $urandom % 4;
         a = 4'($urandom % 11);
         d = 8'($urandom);
         if (a < 4'd8 && a[0] && ($urandom % 4 != 0)) d = 8'h00;
         if (a < 4'd8 && !a[0]) d = d % 8'd16;
         step(op == 1, op == 2, a, d, ($urandom % 2) == 1, ($urandom % 16) == 0);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule